// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder

This block turns the three position-sensor bits of a brushless DC motor into a six-bit bridge drive request. Three bits ask for high-side switches and three ask for low-side switches. In three-phase operation the decoder recognises four sensor mounting conventions: 60, 120, 240 and 300 electrical degrees. It walks the same six-step pair sequence for every convention. Reversing the direction selects the opposite pair for the same sensor state. A sensor code that cannot occur for the chosen mounting removes all drive and drops the valid flag.

A separate mode input selects four-phase operation. In that mode one sensor feeds the first sense bit, and a second sensor feeds both of the other two bits. Each of the four sensor states then requests exactly one output. All inputs are treated as asynchronous and pass through a synchroniser chain. The decoded request is held in a register, so PWM gating, braking and overcurrent logic further downstream see a clean, glitch-free request.

Top module: `hall_commutator`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `drive_o = 0` and `valid_o = 0`.
- R2: With the default `SYNC_STAGES = 2`, the outputs reflect the input values captured three rising edges earlier: two synchroniser flops, then the output register.
- R3: Bit order is `sense_i[2]` = S1, `sense_i[1]` = S2, `sense_i[0]` = S3. `drive_o[0..2]` are the high-side requests O1..O3 and `drive_o[3..5]` are the low-side requests O4..O6.
- R4: With `spacing_i = 2'b01` (120 degrees), three-phase mode and `dir_fwd_i = 1`, the sensor codes 001, 101, 100, 110, 010 and 011 (S1 S2 S3) request O1+O5, O3+O5, O3+O4, O2+O4, O2+O6 and O1+O6 in that order.
- R5: The six requests of R4 are assigned to these codes for the other spacings. Spacing `2'b00` (60 degrees): 000, 100, 110, 111, 011, 001. Spacing `2'b10` (240 degrees): 010, 110, 100, 101, 001, 011. Spacing `2'b11` (300 degrees): 011, 111, 110, 100, 000, 001.
- R6: With `dir_fwd_i = 0` in three-phase mode, each legal code requests the complementary pair. O1+O5 and O2+O4 swap, O3+O5 and O2+O6 swap, and O3+O4 and O1+O6 swap.
- R7: In three-phase mode, codes 010 and 101 are illegal for the 60 and 300 degree spacings, and codes 000 and 111 are illegal for the 120 and 240 degree spacings. An illegal code gives `valid_o = 0` and `drive_o = 0`.
- R8: With `four_phase_i = 1` and S2 = S3, the spacing input is ignored. Forward maps (S1,S2) 00, 10, 11, 01 to O1, O3, O4, O6. Reverse maps the same codes to O4, O6, O1, O3. Exactly one drive bit is set and `valid_o = 1`.
- R9: With `four_phase_i = 1` and S2 different from S3, `valid_o = 0` and `drive_o = 0`.
- R10: Whenever `valid_o = 1` in three-phase mode, exactly one high-side bit and one low-side bit are set. In no mode are the high-side and low-side requests of the same leg (O1/O4, O2/O5, O3/O6) both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_i | input | 3 | Position-sensor bits, S1 in bit 2, asynchronous |
| spacing_i | input | 2 | Sensor spacing select: 00=60, 01=120, 10=240, 11=300 degrees |
| dir_fwd_i | input | 1 | 1 = forward rotation, 0 = reverse |
| four_phase_i | input | 1 | 1 = four-phase single-output decoding |
| drive_o | output | 6 | Bridge drive request, O1..O6 in bits 0..5 |
| valid_o | output | 1 | High when the registered request comes from a legal sensor state |

## Verification
The hardest case to reach from the ports is an input word that changes on every clock. Sensor, spacing, direction and mode then all move while older words are still in the synchroniser, so every output must be traced to the exact input word three edges back. The stimulus first sweeps all 128 combinations of sensor code, spacing, direction and mode, holding each long enough to settle. It then switches to a new pseudo-random word on every cycle, with a mid-run reset, while a delay-line reference model is compared on every clock.

// File: rtl/hall_pkg.sv
`timescale 1ns/1ps
package hall_pkg;
  localparam int SENSE_W = 3;
  localparam int SPACE_W = 2;
  localparam int LEGS    = 3;
  localparam int DRIVE_W = 2 * LEGS;
  localparam int STEPS   = 6;
  localparam int HALF    = STEPS / 2;

  typedef logic [2:0] step_t;

  typedef enum logic [SPACE_W-1:0] {
    SP_60  = 2'b00,
    SP_120 = 2'b01,
    SP_240 = 2'b10,
    SP_300 = 2'b11
  } spacing_e;

  typedef struct packed {
    logic [SENSE_W-1:0] sense;
    logic [SPACE_W-1:0] spacing;
    logic               dir_fwd;
    logic               four_phase;
  } hall_in_t;

  localparam hall_in_t IN_RESET = '{sense: '0, spacing: '0, dir_fwd: 1'b1, four_phase: 1'b0};

  // Drive pair for each step of the forward rotation sequence.
  function automatic logic [DRIVE_W-1:0] pair_bits(input step_t s);
    logic [DRIVE_W-1:0] p;
    case (s)
      3'd0:    p = 6'b010001; // O1 + O5
      3'd1:    p = 6'b010100; // O3 + O5
      3'd2:    p = 6'b001100; // O3 + O4
      3'd3:    p = 6'b001010; // O2 + O4
      3'd4:    p = 6'b100010; // O2 + O6
      3'd5:    p = 6'b100001; // O1 + O6
      default: p = '0;
    endcase
    return p;
  endfunction

  // Output bit for each position in the four-phase cycle.
  function automatic int unsigned quad_bit(input logic [1:0] idx);
    int unsigned b;
    case (idx)
      2'd0:    b = 0; // O1
      2'd1:    b = 2; // O3
      2'd2:    b = 3; // O4
      default: b = 5; // O6
    endcase
    return b;
  endfunction
endpackage

// File: rtl/hall_sync.sv
`timescale 1ns/1ps
module hall_sync #(
  parameter int               WIDTH     = 7,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RESET_VAL;
        else     stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RESET_VAL;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hall_step_decode.sv
`timescale 1ns/1ps
module hall_step_decode
  import hall_pkg::*;
(
  input  logic [SENSE_W-1:0] code,
  input  logic [SPACE_W-1:0] spacing,
  output step_t              step,
  output logic               legal
);
  always_comb begin
    step  = 3'd0;
    legal = 1'b1;
    case (spacing_e'(spacing))
      SP_60: begin
        case (code)
          3'b000:  step = 3'd0;
          3'b100:  step = 3'd1;
          3'b110:  step = 3'd2;
          3'b111:  step = 3'd3;
          3'b011:  step = 3'd4;
          3'b001:  step = 3'd5;
          default: legal = 1'b0;
        endcase
      end
      SP_120: begin
        case (code)
          3'b001:  step = 3'd0;
          3'b101:  step = 3'd1;
          3'b100:  step = 3'd2;
          3'b110:  step = 3'd3;
          3'b010:  step = 3'd4;
          3'b011:  step = 3'd5;
          default: legal = 1'b0;
        endcase
      end
      SP_240: begin
        case (code)
          3'b010:  step = 3'd0;
          3'b110:  step = 3'd1;
          3'b100:  step = 3'd2;
          3'b101:  step = 3'd3;
          3'b001:  step = 3'd4;
          3'b011:  step = 3'd5;
          default: legal = 1'b0;
        endcase
      end
      default: begin
        case (code)
          3'b011:  step = 3'd0;
          3'b111:  step = 3'd1;
          3'b110:  step = 3'd2;
          3'b100:  step = 3'd3;
          3'b000:  step = 3'd4;
          3'b001:  step = 3'd5;
          default: legal = 1'b0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/hall_drive_map.sv
`timescale 1ns/1ps
module hall_drive_map
  import hall_pkg::*;
(
  input  step_t              step,
  input  logic               legal,
  input  logic               dir_fwd,
  input  logic               four_phase,
  input  logic [SENSE_W-1:0] sense,
  output logic [DRIVE_W-1:0] drive,
  output logic               valid
);
  step_t       eff_step;
  logic [1:0]  quad_idx;
  logic [1:0]  quad_eff;

  // Reverse selects the step half a cycle away (complementary pair).
  always_comb begin
    if (dir_fwd)                    eff_step = step;
    else if (step >= step_t'(HALF)) eff_step = step - step_t'(HALF);
    else                            eff_step = step + step_t'(HALF);
  end

  // Four-phase: position of (S1,S2) in the cycle 00,10,11,01.
  always_comb begin
    case (sense[2:1])
      2'b00:   quad_idx = 2'd0;
      2'b10:   quad_idx = 2'd1;
      2'b11:   quad_idx = 2'd2;
      default: quad_idx = 2'd3;
    endcase
    quad_eff = dir_fwd ? quad_idx : quad_idx + 2'd2;
  end

  always_comb begin
    drive = '0;
    valid = 1'b0;
    if (four_phase) begin
      if (sense[1] == sense[0]) begin
        valid = 1'b1;
        drive[quad_bit(quad_eff)] = 1'b1;
      end
    end else if (legal) begin
      valid = 1'b1;
      drive = pair_bits(eff_step);
    end
  end
endmodule

// File: rtl/hall_commutator.sv
`timescale 1ns/1ps
module hall_commutator
  import hall_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic [SPACE_W-1:0] spacing_i,
  input  logic               dir_fwd_i,
  input  logic               four_phase_i,
  output logic [DRIVE_W-1:0] drive_o,
  output logic               valid_o
);
  localparam int IN_W = $bits(hall_in_t);

  hall_in_t           raw_in;
  hall_in_t           sync_in;
  logic [IN_W-1:0]    sync_bits;
  step_t              step;
  logic               legal;
  logic [DRIVE_W-1:0] drive_nxt;
  logic               valid_nxt;

  assign raw_in = '{sense: sense_i, spacing: spacing_i, dir_fwd: dir_fwd_i, four_phase: four_phase_i};

  hall_sync #(
    .WIDTH     (IN_W),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (IN_RESET)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_bits)
  );

  assign sync_in = hall_in_t'(sync_bits);

  hall_step_decode u_step (
    .code    (sync_in.sense),
    .spacing (sync_in.spacing),
    .step    (step),
    .legal   (legal)
  );

  hall_drive_map u_map (
    .step       (step),
    .legal      (legal),
    .dir_fwd    (sync_in.dir_fwd),
    .four_phase (sync_in.four_phase),
    .sense      (sync_in.sense),
    .drive      (drive_nxt),
    .valid      (valid_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o <= '0;
      valid_o <= 1'b0;
    end else begin
      drive_o <= drive_nxt;
      valid_o <= valid_nxt;
    end
  end
endmodule

// File: rtl/hall_commutator_chk.sv
`timescale 1ns/1ps
module hall_commutator_chk (
  input logic       clk,
  input logic       rst,
  input logic       four_phase_i,
  input logic [5:0] drive_o,
  input logic       valid_o
);
  // Edges since reset release, saturating; mode lookback is 3 edges (default sync depth).
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)               warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (drive_o == 6'd0 && !valid_o));

  a_r7_blank_when_invalid: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> drive_o == 6'd0);

  a_r10_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
    !((drive_o[0] & drive_o[3]) | (drive_o[1] & drive_o[4]) | (drive_o[2] & drive_o[5])));

  a_r10_pair_shape: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && !$past(four_phase_i, 3) && valid_o) |->
      ($countones(drive_o[2:0]) == 1 && $countones(drive_o[5:3]) == 1));

  a_r8_single_output: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(four_phase_i, 3) && valid_o) |-> $onehot(drive_o));
endmodule

bind hall_commutator hall_commutator_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .four_phase_i (four_phase_i),
  .drive_o      (drive_o),
  .valid_o      (valid_o)
);

// File: tb/hall_commutator_bench.sv
`timescale 1ns/1ps
module hall_commutator_bench;
  import hall_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  hall_in_t   cur = IN_RESET;
  logic [5:0] drive_o;
  logic       valid_o;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  always #2.5 clk = ~clk;

  hall_commutator u_hall_commutator (
    .clk          (clk),
    .rst          (rst),
    .sense_i      (cur.sense),
    .spacing_i    (cur.spacing),
    .dir_fwd_i    (cur.dir_fwd),
    .four_phase_i (cur.four_phase),
    .drive_o      (drive_o),
    .valid_o      (valid_o)
  );

  // Reference: sequence lookup per spacing (R4, R5), half-cycle shift for reverse (R6).
  // Bit order per R3: S1 is the MSB of the code, drive bit i is output O(i+1).
  function automatic void ref_model(input hall_in_t b, output logic [5:0] d, output logic v);
    int seq [6];
    int hi  [6] = '{0, 2, 2, 1, 1, 0};
    int lo  [6] = '{4, 4, 3, 3, 5, 5};
    int k;
    d = '0;
    v = 1'b0;
    if (b.four_phase) begin
      if (b.sense[1] == b.sense[0]) begin
        v = 1'b1;
        case ({b.dir_fwd, b.sense[2:1]})
          3'b100: d[0] = 1'b1;
          3'b110: d[2] = 1'b1;
          3'b111: d[3] = 1'b1;
          3'b101: d[5] = 1'b1;
          3'b000: d[3] = 1'b1;
          3'b010: d[5] = 1'b1;
          3'b011: d[0] = 1'b1;
          default: d[2] = 1'b1;
        endcase
      end
    end else begin
      case (b.spacing)
        2'd0:    seq = '{0, 4, 6, 7, 3, 1};
        2'd1:    seq = '{1, 5, 4, 6, 2, 3};
        2'd2:    seq = '{2, 6, 4, 5, 1, 3};
        default: seq = '{3, 7, 6, 4, 0, 1};
      endcase
      k = -1;
      for (int i = 0; i < 6; i++) if (seq[i] == int'(b.sense)) k = i;
      if (k >= 0) begin
        if (!b.dir_fwd) k = (k + 3) % 6;
        v = 1'b1;
        d[hi[k]] = 1'b1;
        d[lo[k]] = 1'b1;
      end
    end
  endfunction

  // Delay line: two synchroniser slots, then the registered output (R2).
  hall_in_t   q[$] = '{IN_RESET, IN_RESET};
  logic [5:0] exp_drive = '0;
  logic       exp_valid = 1'b0;
  hall_in_t   exp_src   = IN_RESET;
  bit         exp_rst   = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      q = '{IN_RESET, IN_RESET};
      exp_drive = '0;
      exp_valid = 1'b0;
      exp_rst   = 1'b1;
    end else begin
      exp_src = q[0];
      ref_model(q[0], exp_drive, exp_valid);
      exp_rst = 1'b0;
      void'(q.pop_front());
      q.push_back(cur);
    end
  end

  function automatic string tag_of();
    if (exp_rst)                                         return "R1";
    if (exp_src.four_phase)                              return exp_valid ? "R8" : "R9";
    if (!exp_valid)                                      return "R7";
    if (!exp_src.dir_fwd)                                return "R6";
    if (exp_src.spacing == 2'b01)                        return "R4";
    return "R5";
  endfunction

  task automatic compare();
    string t = tag_of();
    checks++;
    if (drive_o !== exp_drive || valid_o !== exp_valid) begin
      fails++;
      $display("FAIL %s/R2 drive=%b valid=%b expected drive=%b valid=%b (src %p)",
               t, drive_o, valid_o, exp_drive, exp_valid, exp_src);
    end
    if (!exp_rst && !exp_src.four_phase && exp_valid) begin
      checks++; // R10 pair shape
      if ($countones(drive_o[2:0]) != 1 || $countones(drive_o[5:3]) != 1) begin
        fails++;
        $display("FAIL R10 drive=%b expected one high and one low bit", drive_o);
      end
    end
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    compare();                        // R1 reset state
    rst = 1'b0;
    // Exhaustive sweep, each word held long enough to settle.
    for (int m = 0; m < 2; m++)
      for (int dr = 1; dr >= 0; dr--)
        for (int sp = 0; sp < 4; sp++)
          for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            compare();
            cur = '{sense: 3'(c), spacing: 2'(sp), dir_fwd: dr[0], four_phase: m[0]};
            repeat (3) begin @(negedge clk); compare(); end
          end
    // A new word on every cycle, with a reset in the middle.
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      compare();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cur  = hall_in_t'(lfsr[6:0]);
      rst  = (n >= 1500 && n < 1503);
    end
    repeat (4) begin @(negedge clk); compare(); end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule